// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Rate Unit

This block produces the three interrupt sources of a PC-style real-time clock and keeps their status for the host. A programmable divider turns a 32.768 kHz reference pulse into a periodic tick. The tick, a one-cycle alarm-match pulse and a one-cycle update-done pulse each set a sticky flag. A control register holds one enable per source. A summary bit is true while any flag is set together with its enable, and that summary drives the single active-high interrupt line.

The host reaches three byte registers through a register-select, read-strobe and write-strobe interface, with read data returned in the same cycle. Reading the status register returns the flags and clears them at the following clock edge. An event that arrives in the same cycle as that read is kept. Time-of-day counting and alarm comparison happen elsewhere and reach this block only as pulses.

Top module: `rtcIrqRate`

## Requirements
- R1: Register select 0 is the rate register (rate code in bits 3:0, bits 7:4 read 0). Select 1 is control, with enables at bit 6 (periodic), bit 5 (alarm) and bit 4 (update) and every other bit reading 0. Select 2 is status and is read-only. Select 3 reads 0. Writes to selects 2 and 3 have no effect.
- R2: After reset the rate code is 6, control reads 0x00, status reads 0x00 and irq is low.
- R3: A rate code N from 1 to 15 gives one periodic tick every 2^(N-1) reference pulses (2^(16-N) Hz from 32.768 kHz). The reset code 6 therefore gives a tick every 32 reference pulses.
- R4: Rate code 0 produces no periodic ticks.
- R5: Each write to the rate register restarts the divider. With the reference pulsing every cycle, the first tick appears 2^(N-1) - 1 cycles after the write edge, so it lands a full period after the write.
- R6: The periodic tick, the alarm pulse and the update pulse each set their own flag whether or not the matching enable is set.
- R7: A status read returns bit 7 = summary (OR over flag AND enable), bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, and bits 3:0 = 0.
- R8: A status read clears all flags at the next clock edge. A second read shows only events that arrived after the first read.
- R9: An event pulse in the same cycle as a clearing status read leaves its flag set.
- R10: irq equals the summary bit. It falls in the cycle after a clearing read unless an enabled event coincides with that read. Setting an enable for an already-set flag raises irq.
- R11: The divider advances only on cycles where the reference pulse input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle pulse at the 32.768 kHz reference rate |
| alarmHit | input | 1 | One-cycle alarm-match event |
| updateDone | input | 1 | One-cycle update-ended event |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid in the cycle of regRd, 0 otherwise |
| periodTick | output | 1 | Periodic tick, high for one cycle |
| irq | output | 1 | Interrupt request, active high |

## Verification
A table drives alarm and update pulses under every useful enable mask. Each entry shows that the flags ignore the mask while the summary bit and irq follow it. A second read after each entry tells a true clear apart from a flag that only looked clear. The divider is timed at several rate codes, from the fastest to the slowest, by measuring both the first tick after a write and the spacing between ticks, so a wrong exponent or a missing restart shows up as a wrong count. Directed cases cover the rate-off code, a gated reference, a read that collides with an event with and without its enable, a late enable, and writes to read-only selects.

// File: rtl/rtcIrqPkg.sv
package rtcIrqPkg;

  // register select codes seen on regAddr
  typedef enum logic [1:0] {
    RegRate  = 2'd0,
    RegCtrl  = 2'd1,
    RegStat  = 2'd2,
    RegSpare = 2'd3
  } regSelE;

  // strobes from the bus decoder to the datapath
  typedef struct packed {
    logic wrRate;
    logic wrCtrl;
    logic rdStat;
  } busStbT;

  localparam int EVT_N    = 3;  // periodic, alarm, update
  localparam int BIT_PER  = 2;
  localparam int BIT_ALM  = 1;
  localparam int BIT_UPD  = 0;
  localparam int FLAG_LSB = 4;  // flags and enables share byte bits 6:4
  localparam int SUM_BIT  = 7;
  localparam int BYTE_W   = 8;

endpackage

// File: rtl/rtcRateDiv.sv
module rtcRateDiv #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              restart,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) - 2;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] termMask;

  // terminal count 2^(N-1)-1: bit i is set while N exceeds i+1
  for (genvar i = 0; i < CNT_W; i++) begin : gMask
    assign termMask[i] = (rateSel > RATE_W'(i + 1));
  end

  assign tick = refTick && (rateSel != '0) && (cntQ == termMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (restart || tick) begin
      cntQ <= '0;
    end else if (refTick) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rtcIrqDatapath.sv
module rtcIrqDatapath
  import rtcIrqPkg::*;
#(
  parameter int RATE_W   = 4,
  parameter int RATE_RST = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStbT            stb,
  input  logic [RATE_W-1:0] rateIn,
  input  logic [EVT_N-1:0]  enIn,
  input  logic              refTick,
  input  logic              alarmHit,
  input  logic              updateDone,
  output logic [RATE_W-1:0] rateQ,
  output logic [EVT_N-1:0]  enQ,
  output logic [EVT_N-1:0]  flagQ,
  output logic              summary,
  output logic              periodTick
);

  logic [EVT_N-1:0] evt;
  logic [EVT_N-1:0] flagD;

  rtcRateDiv #(.RATE_W(RATE_W)) uDiv (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .restart (stb.wrRate),
    .rateSel (rateQ),
    .tick    (periodTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= RATE_W'(RATE_RST);
      enQ   <= '0;
    end else begin
      if (stb.wrRate) rateQ <= rateIn;
      if (stb.wrCtrl) enQ   <= enIn;
    end
  end

  always_comb begin
    evt          = '0;
    evt[BIT_PER] = periodTick;
    evt[BIT_ALM] = alarmHit;
    evt[BIT_UPD] = updateDone;
    // a clearing read loses against a same-cycle event
    flagD = (stb.rdStat ? '0 : flagQ) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  assign summary = |(flagQ & enQ);

endmodule

// File: rtl/rtcIrqBusCtl.sv
module rtcIrqBusCtl
  import rtcIrqPkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [RATE_W-1:0] rateQ,
  input  logic [EVT_N-1:0]  enQ,
  input  logic [EVT_N-1:0]  flagQ,
  input  logic              summary,
  output busStbT            stb,
  output logic [BYTE_W-1:0] regRdData
);

  regSelE            sel;
  logic [BYTE_W-1:0] rdMux;

  assign sel = regSelE'(regAddr);

  always_comb begin
    stb        = '0;
    stb.wrRate = regWr && (sel == RegRate);
    stb.wrCtrl = regWr && (sel == RegCtrl);
    stb.rdStat = regRd && (sel == RegStat);
  end

  always_comb begin
    rdMux = '0;
    unique case (sel)
      RegRate: rdMux[RATE_W-1:0] = rateQ;
      RegCtrl: rdMux[FLAG_LSB +: EVT_N] = enQ;
      RegStat: begin
        rdMux[FLAG_LSB +: EVT_N] = flagQ;
        rdMux[SUM_BIT]           = summary;
      end
      default: rdMux = '0;
    endcase
  end

  assign regRdData = regRd ? rdMux : '0;

endmodule

// File: rtl/rtcIrqRate.sv
module rtcIrqRate
  import rtcIrqPkg::*;
#(
  parameter int RATE_W   = 4,
  parameter int RATE_RST = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       alarmHit,
  input  logic       updateDone,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       periodTick,
  output logic       irq
);

  busStbT            stb;
  logic [RATE_W-1:0] rateQ;
  logic [EVT_N-1:0]  enQ;
  logic [EVT_N-1:0]  flagQ;
  logic              summary;
  logic              unusedWr;

  assign unusedWr = regWrData[SUM_BIT];

  rtcIrqBusCtl #(.RATE_W(RATE_W)) uBus (
    .regWr     (regWr),
    .regRd     (regRd),
    .regAddr   (regAddr),
    .rateQ     (rateQ),
    .enQ       (enQ),
    .flagQ     (flagQ),
    .summary   (summary),
    .stb       (stb),
    .regRdData (regRdData)
  );

  rtcIrqDatapath #(.RATE_W(RATE_W), .RATE_RST(RATE_RST)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rateIn     (regWrData[RATE_W-1:0]),
    .enIn       (regWrData[FLAG_LSB +: EVT_N]),
    .refTick    (refTick),
    .alarmHit   (alarmHit),
    .updateDone (updateDone),
    .rateQ      (rateQ),
    .enQ        (enQ),
    .flagQ      (flagQ),
    .summary    (summary),
    .periodTick (periodTick)
  );

  assign irq = summary;

endmodule

// File: rtl/rtcIrqRateChk.sv
module rtcIrqRateChk #(
  parameter int RATE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              alarmHit,
  input logic              updateDone,
  input logic              regWr,
  input logic              regRd,
  input logic [1:0]        regAddr,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic              periodTick,
  input logic              irq,
  input logic [2:0]        flagQ,
  input logic [RATE_W-1:0] rateQ
);
  logic statRd;
  logic unusedChk;

  assign statRd    = regRd && (regAddr == 2'd2);
  assign unusedChk = ^regWrData[7:RATE_W];

  AST_SUMMARY_IS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> (irq == regRdData[7])); // R10

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> (regRdData[3:0] == 4'd0)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !alarmHit && !updateDone && !periodTick) |=> (flagQ == 3'd0)); // R8

  AST_ALARM_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |=> flagQ[1]); // R6

  AST_UPDATE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |=> flagQ[0]); // R9

  AST_TICK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (rateQ == '0) |-> !periodTick); // R4

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && regWrData[RATE_W-1:0] > RATE_W'(1)) |=> !periodTick); // R5

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !statRd |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R8

endmodule

bind rtcIrqRate rtcIrqRateChk #(.RATE_W(RATE_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .alarmHit   (alarmHit),
  .updateDone (updateDone),
  .regWr      (regWr),
  .regRd      (regRd),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdData  (regRdData),
  .periodTick (periodTick),
  .irq        (irq),
  .flagQ      (flagQ),
  .rateQ      (rateQ)
);

// File: tb/tb_rtcIrqRate.sv
module tb_rtcIrqRate;
  localparam int CLK_P = 10;
  localparam logic [1:0] A_RATE = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_SPARE = 2'd3;

  // {enables[2:0] (per,alm,upd), alarm pulse, update pulse, expected status}
  localparam logic [12:0] EVT_TBL [0:7] = '{
    {3'b000, 1'b1, 1'b0, 8'h20},
    {3'b010, 1'b1, 1'b0, 8'hA0},
    {3'b001, 1'b1, 1'b0, 8'h20},
    {3'b001, 1'b0, 1'b1, 8'h90},
    {3'b111, 1'b1, 1'b1, 8'hB0},
    {3'b100, 1'b1, 1'b1, 8'h30},
    {3'b011, 1'b0, 1'b0, 8'h00},
    {3'b110, 1'b0, 1'b1, 8'h10}
  };
  localparam int RATE_LIST [0:4] = '{1, 2, 3, 9, 15};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refTick = 1'b1;
  logic alarmHit = 1'b0, updateDone = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic periodTick, irq;

  int total = 0;
  int bad = 0;

  rtcIrqRate dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .alarmHit(alarmHit),
    .updateDone(updateDone), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .periodTick(periodTick), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdRegEv(input logic [1:0] a, input logic al, input logic up,
                         output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a; alarmHit = al; updateDone = up;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0; alarmHit = 1'b0; updateDone = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    rdRegEv(a, 1'b0, 1'b0, d);
  endtask

  task automatic pulse(input logic al, input logic up);
    @(negedge clk);
    alarmHit = al; updateDone = up;
    @(negedge clk);
    alarmHit = 1'b0; updateDone = 1'b0;
  endtask

  // cycles from the current negedge until periodTick is seen
  task automatic firstTick(output int n);
    n = 0;
    while (!periodTick && n < 40000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tickGap(output int m);
    m = 0;
    do begin
      @(negedge clk);
      m++;
    end while (!periodTick && m < 40000);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, m, cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    chkEq("R2 irq after reset", int'(irq), 0);
    rdReg(A_STAT, d); chkEq("R2 status after reset", d, 8'h00);
    rdReg(A_RATE, d); chkEq("R2 rate after reset", d, 8'h06);
    rdReg(A_CTRL, d); chkEq("R2 control after reset", d, 8'h00);

    // R3 reset code gives 32-pulse spacing
    firstTick(n);
    tickGap(m); chkEq("R3 gap at reset rate", m, 32);

    // R4 rate off
    wrReg(A_RATE, 8'h00);
    rdReg(A_STAT, d);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (periodTick) cnt++;
    end
    chkEq("R4 ticks with rate 0", cnt, 0);
    rdReg(A_STAT, d); chkEq("R4 no periodic flag", d, 8'h00);

    // R6 R7 R8 R10 event table
    foreach (EVT_TBL[i]) begin
      wrReg(A_CTRL, {1'b0, EVT_TBL[i][12:10], 4'h0});
      pulse(EVT_TBL[i][9], EVT_TBL[i][8]);
      chkEq("R10 irq follows summary", int'(irq), int'(EVT_TBL[i][7]));
      rdReg(A_STAT, d); chkEq("R7 status byte", d, int'(EVT_TBL[i][7:0]));
      rdReg(A_STAT, d); chkEq("R8 second read empty", d, 8'h00);
    end

    // R6 periodic flag sets with its enable clear
    wrReg(A_CTRL, 8'h00);
    wrReg(A_RATE, 8'h01);
    wrReg(A_RATE, 8'h00);
    chkEq("R6 irq low with PIE clear", int'(irq), 0);
    rdReg(A_STAT, d); chkEq("R6 periodic flag", d, 8'h40);

    // R1 map details
    wrReg(A_CTRL, 8'hFF);
    rdReg(A_CTRL, d); chkEq("R1 control unused bits", d, 8'h70);
    wrReg(A_STAT, 8'hFF);
    rdReg(A_STAT, d); chkEq("R1 status write ignored", d, 8'h00);
    wrReg(A_SPARE, 8'hFF);
    rdReg(A_SPARE, d); chkEq("R1 spare reads zero", d, 8'h00);
    rdReg(A_RATE, d); chkEq("R1 rate unchanged", d, 8'h00);
    rdReg(A_CTRL, d); chkEq("R1 control unchanged", d, 8'h70);

    // R9 coincident event with enables clear
    wrReg(A_CTRL, 8'h00);
    rdRegEv(A_STAT, 1'b1, 1'b0, d); chkEq("R9 read before event", d, 8'h00);
    rdReg(A_STAT, d); chkEq("R9 alarm kept", d, 8'h20);

    // R10 irq drop and hold
    wrReg(A_CTRL, 8'h20);
    pulse(1'b1, 1'b0);
    chkEq("R10 irq raised", int'(irq), 1);
    rdReg(A_STAT, d); chkEq("R10 status", d, 8'hA0);
    chkEq("R10 irq dropped after read", int'(irq), 0);
    pulse(1'b1, 1'b0);
    rdRegEv(A_STAT, 1'b1, 1'b0, d); chkEq("R10 status on colliding read", d, 8'hA0);
    chkEq("R10 irq held by enabled event", int'(irq), 1);
    rdReg(A_STAT, d); chkEq("R10 flag still set", d, 8'hA0);
    wrReg(A_CTRL, 8'h00);
    pulse(1'b0, 1'b1);
    chkEq("R10 irq low while disabled", int'(irq), 0);
    wrReg(A_CTRL, 8'h10);
    chkEq("R10 late enable raises irq", int'(irq), 1);
    rdReg(A_STAT, d); chkEq("R10 status after late enable", d, 8'h90);
    wrReg(A_CTRL, 8'h00);

    // R5 restart on rewrite
    wrReg(A_RATE, 8'h03);
    @(negedge clk); @(negedge clk);
    wrReg(A_RATE, 8'h03);
    firstTick(n); chkEq("R5 first tick after rewrite", n, 3);

    // R11 gated reference, rate 2
    wrReg(A_RATE, 8'h02);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      refTick = (k % 2 == 0);
      #1 if (periodTick) cnt++;
    end
    refTick = 1'b1;
    chkEq("R11 ticks with half-rate reference", cnt, 10);

    // R3 R5 rate sweep
    foreach (RATE_LIST[i]) begin
      wrReg(A_RATE, 8'(RATE_LIST[i]));
      firstTick(n); chkEq("R5 first tick delay", n, (1 << (RATE_LIST[i] - 1)) - 1);
      tickGap(m);   chkEq("R3 tick spacing", m, 1 << (RATE_LIST[i] - 1));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule